// File: doc/BRIEF.md
# Armable Data-Value Watchpoint Channel

This block is one debug watchpoint channel. It observes data beats on a bus of up to four byte lanes and emits a single-cycle detection pulse when the beat's valid lanes satisfy a programmed comparison against a reference value. The comparison can be equal, not equal, greater than or less than. The beat must also be of the chosen access direction, read or write. Each lane is compared, unsigned, with the same lane of the reference. Lanes whose valid flag is low take no part.

A 4-bit enable field controls whether the channel is live. Software may disable it, enable it, or arm it. An armed channel waits for one of eight event strobes from sibling channels, for a count-event strobe, or for the external event pin. When the selected event arrives, hardware rewrites the field so that the channel becomes enabled. The pin-armed mode enables the channel only while the pin stays asserted, and it falls back to disabled when the pin drops. The current value of the field is always visible on an output.

The data side is a valid/ready stream. The channel only observes traffic, so `bus_ready` is held high at all times. A beat counts as observed in every cycle where `bus_valid` is high, and the channel never applies back-pressure.

Top module: `wp_value_channel`

## Requirements
- R1: After reset, `en_field` is 0000 and `hit` is 0.
- R2: With `en_field` at 0000, or at a reserved value from 1100 to 1110, the channel never pulses `hit`. In these states the field changes only through a software write, and arming strobes have no effect on it.
- R3: Value 1111 keeps the channel enabled until software writes a new value. A qualifying beat in cycle t sets `hit` high for exactly cycle t+1.
- R4: A value k from 0001 to 1000 arms the channel on `arm_evt[k-1]`. Strobes on any other index are ignored. One cycle after the strobe, `en_field` reads 1111, and beats from that cycle onward can produce a hit.
- R5: Value 1001 arms the channel on `cnt_evt`. One cycle later `en_field` becomes 1111.
- R6: Value 1010 moves to 1011 when `ext_pin` is high and `ext_pin_is_input` is high. If `ext_pin_is_input` is low, the pin is ignored and the field stays at 1010.
- R7: Value 1011 is enabled. When `ext_pin` is low, the field returns to 0000 on the next cycle. A software write of 1011 stores 0000, so 1011 can only be reached from 1010.
- R8: `cond_sel` selects the comparison: 00 is equal, 01 is not equal, 10 is data greater than reference, and 11 is data less than reference. Each comparison is unsigned per byte lane, and lane i of `bus_data` (bits 8i+7:8i) is compared with lane i of `ref_val`.
- R9: Equal, greater and less hold if any valid lane satisfies them. Not-equal holds only if every valid lane differs. With no valid lane, no condition holds.
- R10: With `acc_write_sel` at 0, only beats with `bus_write` = 0 (reads) are compared. With `acc_write_sel` at 1, only beats with `bus_write` = 1 (writes) are compared.
- R11: When a software write (`en_wr`) and a hardware arming update fall in the same cycle, the written value wins.
- R12: `bus_ready` is always 1. A cycle with `bus_valid` low never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Software write strobe for the enable field |
| en_wr_val | input | 4 | Value written to the enable field |
| cond_sel | input | 2 | Comparison select |
| acc_write_sel | input | 1 | Access direction select (0 read, 1 write) |
| ref_val | input | 32 | Reference value, one byte per lane |
| bus_valid | input | 1 | Beat present on the data bus |
| bus_ready | output | 1 | Always high; the channel only observes |
| bus_data | input | 32 | Beat data, four byte lanes |
| bus_lane_vld | input | 4 | Per-lane operand valid flags |
| bus_write | input | 1 | Beat direction (1 write, 0 read) |
| arm_evt | input | 8 | Event strobes from sibling channels |
| cnt_evt | input | 1 | Count-event strobe |
| ext_pin | input | 1 | External event pin level |
| ext_pin_is_input | input | 1 | Pin configured as an input |
| en_field | output | 4 | Current enable field |
| hit | output | 1 | Detection pulse |

## Verification
Two functions can collide in one cycle: a software write to the enable field and a hardware arming update driven by a strobe or by the pin. The bench provokes this by asserting a software write together with the very strobe that would arm the channel, and it expects the written value to appear. A second collision happens when the pin drops while the channel sits in the pin-enabled state and a matching beat arrives in the same cycle. That beat must still produce a hit, because the comparison uses the field value from before the update, and the field must read 0000 afterwards. Random stimulus then mixes writes, strobes, pin changes and beats, and a behavioural model checks the outputs on every clock.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    COND_EQ = 2'b00,
    COND_NE = 2'b01,
    COND_GT = 2'b10,
    COND_LT = 2'b11
  } cond_e;

  localparam logic [3:0] EN_OFF      = 4'h0;
  localparam logic [3:0] EN_CNT      = 4'h9;
  localparam logic [3:0] EN_PIN_WAIT = 4'hA;
  localparam logic [3:0] EN_PIN_ON   = 4'hB;
  localparam logic [3:0] EN_ON       = 4'hF;

  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } lane_res_t;
endpackage

// File: rtl/wp_lane_cmp.sv
module wp_lane_cmp #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] data_i,
  input  logic [LANE_W-1:0] ref_i,
  output wp_pkg::lane_res_t res_o
);
  // unsigned relation of one byte lane to its reference lane
  always_comb begin
    res_o.eq = (data_i == ref_i);
    res_o.gt = (data_i >  ref_i);
    res_o.lt = (data_i <  ref_i);
  end
endmodule

// File: rtl/wp_cond_reduce.sv
module wp_cond_reduce #(
  parameter int LANES = 4
) (
  input  wp_pkg::lane_res_t [LANES-1:0] res_i,
  input  logic [LANES-1:0]              vld_i,
  input  logic [1:0]                    cond_i,
  output logic                          match_o
);
  import wp_pkg::*;

  logic [LANES-1:0] eq_v, gt_v, lt_v;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign eq_v[g] = res_i[g].eq & vld_i[g];
    assign gt_v[g] = res_i[g].gt & vld_i[g];
    assign lt_v[g] = res_i[g].lt & vld_i[g];
  end

  logic any_vld, any_eq, any_gt, any_lt, all_ne;
  assign any_vld = |vld_i;
  assign any_eq  = |eq_v;
  assign any_gt  = |gt_v;
  assign any_lt  = |lt_v;
  // every valid lane must differ; no valid lane means no match
  assign all_ne  = any_vld & ~any_eq;

  always_comb begin
    unique case (cond_e'(cond_i))
      COND_EQ: match_o = any_eq;
      COND_NE: match_o = all_ne;
      COND_GT: match_o = any_gt;
      COND_LT: match_o = any_lt;
      default: match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wp_arm_fsm.sv
module wp_arm_fsm #(
  parameter int N_ARM = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_i,
  input  logic [3:0]       sw_val_i,
  input  logic [N_ARM-1:0] arm_evt_i,
  input  logic             cnt_evt_i,
  input  logic             pin_i,
  input  logic             pin_is_in_i,
  output logic [3:0]       field_o,
  output logic             active_o
);
  import wp_pkg::*;

  localparam int          IDX_W  = (N_ARM > 1) ? $clog2(N_ARM) : 1;
  localparam logic [3:0]  ARM_HI = 4'(N_ARM);

  logic [3:0]       field_q, field_d;
  logic [3:0]       idx_full;
  logic [IDX_W-1:0] idx;
  logic             in_arm_range;

  assign idx_full     = field_q - 4'd1;
  assign idx          = idx_full[IDX_W-1:0];
  assign in_arm_range = (field_q != EN_OFF) && (field_q <= ARM_HI);

  always_comb begin
    field_d = field_q;
    if (in_arm_range) begin
      if (arm_evt_i[idx]) field_d = EN_ON;
    end else begin
      case (field_q)
        EN_CNT:      if (cnt_evt_i)             field_d = EN_ON;
        EN_PIN_WAIT: if (pin_is_in_i && pin_i)  field_d = EN_PIN_ON;
        EN_PIN_ON:   if (!pin_i)                field_d = EN_OFF;
        default:     field_d = field_q;
      endcase
    end
    // software write wins; pin-enabled state is not directly writable
    if (sw_wr_i) field_d = (sw_val_i == EN_PIN_ON) ? EN_OFF : sw_val_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) field_q <= EN_OFF;
    else        field_q <= field_d;
  end

  assign field_o  = field_q;
  assign active_o = (field_q == EN_ON) || (field_q == EN_PIN_ON);
endmodule

// File: rtl/wp_value_channel.sv
module wp_value_channel #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int N_ARM  = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic [3:0]       en_wr_val,
  input  logic [1:0]       cond_sel,
  input  logic             acc_write_sel,
  input  logic [DW-1:0]    ref_val,
  input  logic             bus_valid,
  output logic             bus_ready,
  input  logic [DW-1:0]    bus_data,
  input  logic [LANES-1:0] bus_lane_vld,
  input  logic             bus_write,
  input  logic [N_ARM-1:0] arm_evt,
  input  logic             cnt_evt,
  input  logic             ext_pin,
  input  logic             ext_pin_is_input,
  output logic [3:0]       en_field,
  output logic             hit
);
  import wp_pkg::*;

  lane_res_t [LANES-1:0] lane_res;
  logic                  cond_match;
  logic                  active;
  logic                  dir_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wp_lane_cmp #(.LANE_W(LANE_W)) u_cmp (
      .data_i (bus_data[g*LANE_W +: LANE_W]),
      .ref_i  (ref_val [g*LANE_W +: LANE_W]),
      .res_o  (lane_res[g])
    );
  end

  wp_cond_reduce #(.LANES(LANES)) u_reduce (
    .res_i   (lane_res),
    .vld_i   (bus_lane_vld),
    .cond_i  (cond_sel),
    .match_o (cond_match)
  );

  wp_arm_fsm #(.N_ARM(N_ARM)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_wr_i     (en_wr),
    .sw_val_i    (en_wr_val),
    .arm_evt_i   (arm_evt),
    .cnt_evt_i   (cnt_evt),
    .pin_i       (ext_pin),
    .pin_is_in_i (ext_pin_is_input),
    .field_o     (en_field),
    .active_o    (active)
  );

  assign bus_ready = 1'b1;
  assign dir_ok    = (bus_write == acc_write_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= active && bus_valid && dir_ok && cond_match;
  end
endmodule

// File: rtl/wp_value_channel_chk.sv
module wp_value_channel_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_wr,
  input logic [3:0]       en_wr_val,
  input logic             bus_valid,
  input logic             bus_ready,
  input logic [LANES-1:0] bus_lane_vld,
  input logic             cnt_evt,
  input logic             ext_pin,
  input logic [3:0]       en_field,
  input logic             hit
);
  assert_hit_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($past(en_field) == 4'hF || $past(en_field) == 4'hB));

  assert_no_hit_idle_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !hit);

  assert_ready_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready);

  assert_no_lane_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_lane_vld == '0) |=> !hit);

  assert_cnt_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_wr && en_field == 4'h9 && cnt_evt) |=> en_field == 4'hF);

  assert_pin_on_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_field == 4'hB && $past(en_field) != 4'hB) |-> $past(en_field) == 4'hA);

  assert_pin_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_wr && en_field == 4'hB && !ext_pin) |=> en_field == 4'h0);

  assert_reserved_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_wr && en_field >= 4'hC && en_field <= 4'hE) |=> $stable(en_field));

  assert_sw_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && en_wr_val != 4'hB) |=> en_field == $past(en_wr_val));
endmodule

bind wp_value_channel wp_value_channel_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_wr        (en_wr),
  .en_wr_val    (en_wr_val),
  .bus_valid    (bus_valid),
  .bus_ready    (bus_ready),
  .bus_lane_vld (bus_lane_vld),
  .cnt_evt      (cnt_evt),
  .ext_pin      (ext_pin),
  .en_field     (en_field),
  .hit          (hit)
);

// File: tb/wp_value_channel_tb.sv
`timescale 1ns/1ps
module wp_value_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_wr = 1'b0;
  logic [3:0]  en_wr_val = 4'h0;
  logic [1:0]  cond_sel = 2'b00;
  logic        acc_write_sel = 1'b0;
  logic [31:0] ref_val = 32'h4030_2010;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic [31:0] bus_data = '0;
  logic [3:0]  bus_lane_vld = '0;
  logic        bus_write = 1'b0;
  logic [7:0]  arm_evt = '0;
  logic        cnt_evt = 1'b0;
  logic        ext_pin = 1'b0;
  logic        ext_pin_is_input = 1'b0;
  logic [3:0]  en_field;
  logic        hit;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  wp_value_channel u_dut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wr_val(en_wr_val),
    .cond_sel(cond_sel), .acc_write_sel(acc_write_sel), .ref_val(ref_val),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_data(bus_data),
    .bus_lane_vld(bus_lane_vld), .bus_write(bus_write), .arm_evt(arm_evt),
    .cnt_evt(cnt_evt), .ext_pin(ext_pin), .ext_pin_is_input(ext_pin_is_input),
    .en_field(en_field), .hit(hit)
  );

  // ---------------- behavioural reference model ----------------
  logic [3:0] m_field = 4'h0;
  logic       m_hit   = 1'b0;

  function automatic bit beat_match(input logic [31:0] d, input logic [31:0] r,
                                    input logic [3:0] v, input logic [1:0] c);
    int n_valid = 0, n_eq = 0, n_gt = 0, n_lt = 0;
    for (int i = 0; i < 4; i++) begin
      int dv, rv;
      dv = int'(d[i*8 +: 8]);
      rv = int'(r[i*8 +: 8]);
      if (v[i]) begin
        n_valid++;
        if (dv == rv) n_eq++;
        if (dv >  rv) n_gt++;
        if (dv <  rv) n_lt++;
      end
    end
    case (c)
      2'b00:   return n_eq > 0;
      2'b01:   return (n_valid > 0) && (n_eq == 0);
      2'b10:   return n_gt > 0;
      default: return n_lt > 0;
    endcase
  endfunction

  function automatic logic [3:0] model_next(input logic [3:0] f);
    int k;
    logic [3:0] n;
    k = int'(f);
    n = f;
    if (k >= 1 && k <= 8) begin
      if (arm_evt[k-1]) n = 4'hF;
    end else if (k == 9) begin
      if (cnt_evt) n = 4'hF;
    end else if (k == 10) begin
      if (ext_pin && ext_pin_is_input) n = 4'hB;
    end else if (k == 11) begin
      if (!ext_pin) n = 4'h0;
    end
    if (en_wr) n = (en_wr_val == 4'hB) ? 4'h0 : en_wr_val;
    return n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_field <= 4'h0;
      m_hit   <= 1'b0;
    end else begin
      m_hit   <= (m_field == 4'hF || m_field == 4'hB) && bus_valid &&
                 (bus_write == acc_write_sel) &&
                 beat_match(bus_data, ref_val, bus_lane_vld, cond_sel);
      m_field <= model_next(m_field);
    end
  end

  // ---------------- check helpers ----------------
  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cycles++;
    check_eq(cur_tag, "model en_field", int'(en_field), int'(m_field));
    check_eq(cur_tag, "model hit", int'(hit), int'(m_hit));
    check_eq("R12", "bus_ready", int'(bus_ready), 1);
  endtask

  task automatic quiet();
    en_wr = 0; bus_valid = 0; arm_evt = '0; cnt_evt = 0;
  endtask

  task automatic wr(input logic [3:0] v);
    en_wr = 1; en_wr_val = v;
    tick();
    en_wr = 0;
  endtask

  task automatic beat(input logic [31:0] d, input logic [3:0] v, input logic w,
                      input string tag, input bit exp_hit);
    bus_valid = 1; bus_data = d; bus_lane_vld = v; bus_write = w;
    tick();
    bus_valid = 0;
    check_eq(tag, "hit", int'(hit), int'(exp_hit));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_eq("R1", "reset en_field", int'(en_field), 0);
    check_eq("R1", "reset hit", int'(hit), 0);
    rst_n = 1;

    // R2: disabled and reserved
    cur_tag = "R2";
    beat(32'h0000_0010, 4'b0001, 1'b0, "R2", 1'b0);
    arm_evt = 8'hFF; cnt_evt = 1; tick(); quiet();
    check_eq("R2", "off ignores strobes", int'(en_field), 0);
    wr(4'hD);
    arm_evt = 8'hFF; cnt_evt = 1; ext_pin = 1; ext_pin_is_input = 1; tick(); quiet();
    ext_pin = 0;
    check_eq("R2", "reserved holds", int'(en_field), 13);
    beat(32'h0000_0010, 4'b0001, 1'b0, "R2", 1'b0);

    // R3, R8, R9, R10: enabled comparisons
    cur_tag = "R8";
    wr(4'hF);
    check_eq("R3", "enabled field", int'(en_field), 15);
    cond_sel = 2'b00;
    beat(32'h0000_0010, 4'b0001, 1'b0, "R3", 1'b1);
    tick();
    check_eq("R3", "hit one cycle", int'(hit), 0);
    beat(32'h0000_0010, 4'b0010, 1'b0, "R9", 1'b0);
    beat(32'h4000_0000, 4'b1111, 1'b0, "R9", 1'b1);
    cond_sel = 2'b01;
    beat(32'h4131_2111, 4'b1111, 1'b0, "R9", 1'b1);
    beat(32'h4130_2111, 4'b1111, 1'b0, "R9", 1'b0);
    beat(32'h4130_2111, 4'b0000, 1'b0, "R9", 1'b0);
    cond_sel = 2'b10;
    beat(32'h0000_0011, 4'b0001, 1'b0, "R8", 1'b1);
    beat(32'h0000_0010, 4'b0001, 1'b0, "R8", 1'b0);
    beat(32'h0000_00FF, 4'b0001, 1'b0, "R8", 1'b1);
    cond_sel = 2'b11;
    beat(32'h0000_000F, 4'b0001, 1'b0, "R8", 1'b1);
    beat(32'h0000_00FF, 4'b0001, 1'b0, "R8", 1'b0);
    cond_sel = 2'b00;
    cur_tag = "R10";
    beat(32'h0000_0010, 4'b0001, 1'b1, "R10", 1'b0);
    acc_write_sel = 1;
    beat(32'h0000_0010, 4'b0001, 1'b1, "R10", 1'b1);
    beat(32'h0000_0010, 4'b0001, 1'b0, "R10", 1'b0);
    acc_write_sel = 0;
    cur_tag = "R12";
    bus_data = 32'h0000_0010; bus_lane_vld = 4'b0001; bus_valid = 0; tick();
    check_eq("R12", "no beat no hit", int'(hit), 0);
    check_eq("R3", "stays enabled", int'(en_field), 15);

    // R4: each arming index
    cur_tag = "R4";
    for (int k = 1; k <= 8; k++) begin
      wr(4'(k));
      arm_evt = ~(8'h1 << (k-1)); tick(); quiet();
      check_eq("R4", "wrong strobe ignored", int'(en_field), k);
      beat(32'h0000_0010, 4'b0001, 1'b0, "R4", 1'b0);
      arm_evt = 8'h1 << (k-1); tick(); quiet();
      check_eq("R4", "armed to enabled", int'(en_field), 15);
      beat(32'h0000_0010, 4'b0001, 1'b0, "R4", 1'b1);
    end

    // R5: count arming
    cur_tag = "R5";
    wr(4'h9);
    arm_evt = 8'hFF; tick(); quiet();
    check_eq("R5", "waits for count", int'(en_field), 9);
    cnt_evt = 1; tick(); quiet();
    check_eq("R5", "count arms", int'(en_field), 15);

    // R6, R7: pin modes
    cur_tag = "R6";
    wr(4'hA);
    ext_pin = 1; ext_pin_is_input = 0; tick();
    check_eq("R6", "pin not input ignored", int'(en_field), 10);
    ext_pin_is_input = 1; tick();
    check_eq("R6", "pin arms", int'(en_field), 11);
    cur_tag = "R7";
    beat(32'h0000_0010, 4'b0001, 1'b0, "R7", 1'b1);
    ext_pin = 0;
    beat(32'h0000_0010, 4'b0001, 1'b0, "R7", 1'b1);
    check_eq("R7", "pin drop disables", int'(en_field), 0);
    beat(32'h0000_0010, 4'b0001, 1'b0, "R7", 1'b0);
    wr(4'hF);
    wr(4'hB);
    check_eq("R7", "write 1011 stores off", int'(en_field), 0);

    // R11: write collides with arming
    cur_tag = "R11";
    wr(4'h1);
    arm_evt = 8'h01; en_wr = 1; en_wr_val = 4'h3; tick(); quiet();
    check_eq("R11", "write beats strobe", int'(en_field), 3);
    wr(4'h9);
    cnt_evt = 1; en_wr = 1; en_wr_val = 4'h0; tick(); quiet();
    check_eq("R11", "write beats count", int'(en_field), 0);

    // random mix against the model
    cur_tag = "R3";
    ref_val = 32'h0201_0302;
    for (int i = 0; i < 3000; i++) begin
      en_wr         = ($urandom_range(0, 9) == 0);
      en_wr_val     = 4'($urandom);
      cond_sel      = 2'($urandom);
      acc_write_sel = ($urandom_range(0, 7) == 0) ? ~acc_write_sel : acc_write_sel;
      bus_valid     = 1'($urandom);
      bus_data      = {6'd0, 2'($urandom), 6'd0, 2'($urandom), 6'd0, 2'($urandom), 6'd0, 2'($urandom)};
      bus_lane_vld  = 4'($urandom);
      bus_write     = 1'($urandom);
      arm_evt       = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      cnt_evt       = ($urandom_range(0, 5) == 0);
      ext_pin       = ($urandom_range(0, 3) != 0) ? ext_pin : ~ext_pin;
      ext_pin_is_input = ($urandom_range(0, 15) == 0) ? ~ext_pin_is_input : ext_pin_is_input;
      tick();
    end
    quiet();
    tick();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule